// File: doc/BRIEF.md
# Multi-Block SHA-256 Compression Core

This core turns a packet of already padded 512-bit message blocks into a 256-bit SHA-256 digest. Blocks arrive one at a time on a valid/ready stream that carries a last-of-packet flag and a packet tag. The core keeps a running eight-word hash state. On the first block of every packet it loads the standard SHA-256 initial values into that state. For each block it copies the state into the working variables and runs the 64 compression rounds, one per clock. It then adds the working variables back into the state. After a block that is not the last, the core returns to waiting and the state carries forward into the next block. After the last block it presents the state as the digest, together with the tag of the packet's first block, and holds both until the consumer takes them.

A fixed controller with four states sequences the work: waiting and initialising, setting up the working variables, calculating, and presenting the output. The message schedule is a rolling window of sixteen 32-bit words. Each later schedule word is produced on the fly as the window shifts. The core does no padding, no reordering and no bus access. It sits behind a message builder that supplies the padded blocks.

Top module: `sha256_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: For a one-block packet the digest equals SHA-256 of the message. Word j of the block (j = 0 first) is `in_block[511-32j -: 32]`, and word j of the digest (j = 0 first) is `out_digest[255-32j -: 32]`.
- R3: For a packet of several blocks the hash state is chained from block to block. No digest is offered until the block flagged `in_last` has been processed.
- R4: Every new packet starts from the SHA-256 initial hash values, whatever packet came before it.
- R5: `out_valid` rises on the 65th rising edge after the edge that accepts a last block: 1 setup cycle plus 64 round cycles.
- R6: `in_ready` falls on the cycle after a block is accepted and stays low until the core is waiting again. It is also low while a digest is offered. `in_valid` and the block inputs have no effect while `in_ready` is low.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_digest` and `out_id` stay unchanged. After the handshake edge, `out_valid` is 0.
- R8: `out_id` equals the `in_id` of the packet's first block. The `in_id` values of later blocks in the same packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Core can accept a block |
| in_block | input | 512 | Padded message block, word 0 in the top bits |
| in_last | input | 1 | Block is the last of its packet |
| in_id | input | ID_W | Packet tag, sampled on the first block |
| out_valid | output | 1 | Digest offered |
| out_ready | input | 1 | Consumer takes the digest |
| out_digest | output | 256 | SHA-256 digest, first word in the top bits |
| out_id | output | ID_W | Tag of the packet that produced the digest |

## Verification
The hardest situation to reach is one where state left over from an earlier packet could leak into a later one. This happens when a two-block packet is followed directly by a one-block packet, or when a digest is held back while new blocks are offered and ignored. The vector table chains the empty message, "abc", a two-block message and "abc" again, so a missing reinitialisation shows up as a wrong digest. A directed test stalls the consumer and keeps offering a junk block. It then checks that the held digest does not change and that the next packet still hashes correctly.

// File: rtl/sha_pkg.sv
package sha_pkg;

    localparam int BLOCK_W  = 512;
    localparam int DIGEST_W = 256;
    localparam int WORD_W   = 32;
    localparam int WIN_N    = BLOCK_W / WORD_W;
    localparam int ROUNDS   = 64;
    localparam int RND_W    = $clog2(ROUNDS);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } sha_vars_t;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_SETUP = 2'd1,
        ST_CALC  = 2'd2,
        ST_OUT   = 2'd3
    } sha_state_e;

    localparam sha_vars_t IV = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    localparam word_t K_TAB [ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_s0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_s1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic sha_vars_t add_vars(sha_vars_t p, sha_vars_t q);
        sha_vars_t r;
        r.a = p.a + q.a;
        r.b = p.b + q.b;
        r.c = p.c + q.c;
        r.d = p.d + q.d;
        r.e = p.e + q.e;
        r.f = p.f + q.f;
        r.g = p.g + q.g;
        r.h = p.h + q.h;
        return r;
    endfunction

endpackage

// File: rtl/sha_sched.sv
module sha_sched
    import sha_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [BLOCK_W-1:0] blk,
    output word_t              w_cur
);

    word_t win [WIN_N];
    word_t w_new;

    assign w_new = sml_s1(win[WIN_N-2]) + win[WIN_N-7] + sml_s0(win[1]) + win[0];
    assign w_cur = win[0];

    for (genvar i = 0; i < WIN_N; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win[i] <= '0;
            end else if (load) begin
                win[i] <= blk[BLOCK_W-1-WORD_W*i -: WORD_W];
            end else if (step) begin
                if (i == WIN_N - 1) begin
                    win[i] <= w_new;
                end else begin
                    win[i] <= win[(i + 1) % WIN_N];
                end
            end
        end
    end

endmodule

// File: rtl/sha_round.sv
module sha_round
    import sha_pkg::*;
(
    input  sha_vars_t cur,
    input  word_t     k,
    input  word_t     w,
    output sha_vars_t nxt
);

    word_t t1;
    word_t t2;
    word_t ch;
    word_t maj;

    always_comb begin
        ch    = (cur.e & cur.f) ^ (~cur.e & cur.g);
        maj   = (cur.a & cur.b) ^ (cur.a & cur.c) ^ (cur.b & cur.c);
        t1    = cur.h + big_s1(cur.e) + ch + k + w;
        t2    = big_s0(cur.a) + maj;
        nxt.h = cur.g;
        nxt.g = cur.f;
        nxt.f = cur.e;
        nxt.e = cur.d + t1;
        nxt.d = cur.c;
        nxt.c = cur.b;
        nxt.b = cur.a;
        nxt.a = t1 + t2;
    end

endmodule

// File: rtl/sha_ctrl.sv
module sha_ctrl
    import sha_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             accept,
    output logic             first_blk,
    output logic             load_vars,
    output logic             do_round,
    output logic             fold,
    output logic [RND_W-1:0] rnd
);

    sha_state_e state;
    logic       last_q;
    logic       pkt_start;
    logic       rnd_end;

    assign in_ready  = (state == ST_INIT);
    assign out_valid = (state == ST_OUT);
    assign accept    = in_ready && in_valid;
    assign first_blk = pkt_start;
    assign load_vars = (state == ST_SETUP);
    assign do_round  = (state == ST_CALC);
    assign rnd_end   = (rnd == RND_W'(ROUNDS - 1));
    assign fold      = do_round && rnd_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            last_q    <= 1'b0;
            pkt_start <= 1'b1;
            rnd       <= '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    if (in_valid) begin
                        last_q    <= in_last;
                        pkt_start <= 1'b0;
                        state     <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    rnd   <= '0;
                    state <= ST_CALC;
                end
                ST_CALC: begin
                    rnd <= rnd + 1'b1;
                    if (rnd_end) begin
                        state <= last_q ? ST_OUT : ST_INIT;
                    end
                end
                ST_OUT: begin
                    if (out_ready) begin
                        pkt_start <= 1'b1;
                        state     <= ST_INIT;
                    end
                end
                default: state <= ST_INIT;
            endcase
        end
    end

endmodule

// File: rtl/sha256_core.sv
module sha256_core
    import sha_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BLOCK_W-1:0]  in_block,
    input  logic                in_last,
    input  logic [ID_W-1:0]     in_id,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DIGEST_W-1:0] out_digest,
    output logic [ID_W-1:0]     out_id
);

    logic             accept;
    logic             first_blk;
    logic             load_vars;
    logic             do_round;
    logic             fold;
    logic [RND_W-1:0] rnd;
    word_t            w_cur;
    sha_vars_t        hstate;
    sha_vars_t        vars;
    sha_vars_t        vars_nxt;
    logic [ID_W-1:0]  id_q;

    sha_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .accept    (accept),
        .first_blk (first_blk),
        .load_vars (load_vars),
        .do_round  (do_round),
        .fold      (fold),
        .rnd       (rnd)
    );

    sha_sched u_sched (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .step  (do_round),
        .blk   (in_block),
        .w_cur (w_cur)
    );

    sha_round u_round (
        .cur (vars),
        .k   (K_TAB[rnd]),
        .w   (w_cur),
        .nxt (vars_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hstate <= IV;
            vars   <= '0;
            id_q   <= '0;
        end else begin
            if (accept && first_blk) begin
                hstate <= IV;
                id_q   <= in_id;
            end else if (fold) begin
                hstate <= add_vars(hstate, vars_nxt);
            end
            if (load_vars) begin
                vars <= hstate;
            end else if (do_round) begin
                vars <= vars_nxt;
            end
        end
    end

    assign out_digest = hstate;
    assign out_id     = id_q;

endmodule

// File: rtl/sha256_core_chk.sv
module sha256_core_chk
    import sha_pkg::*;
#(
    parameter int ID_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                in_last,
    input logic                out_valid,
    input logic                out_ready,
    input logic [DIGEST_W-1:0] out_digest,
    input logic [ID_W-1:0]     out_id
);

    localparam int LAT = ROUNDS + 1;

    logic [7:0] since_acc;
    logic       last_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_acc <= 8'hff;
            last_acc  <= 1'b0;
        end else if (in_valid && in_ready) begin
            since_acc <= '0;
            last_acc  <= in_last;
        end else if (since_acc != 8'hff) begin
            since_acc <= since_acc + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R6
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    ready_out_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_digest) && $stable(out_id)));

    // R7
    out_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (last_acc && since_acc == 8'(LAT)));

endmodule

bind sha256_core sha256_core_chk #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_digest (out_digest),
    .out_id     (out_id)
);

// File: tb/sha256_core_bench.sv
`timescale 1ns/1ps
module sha256_core_bench;

    localparam int ID_W = 8;

    typedef struct packed {
        logic [511:0]    blk;
        logic            last;
        logic [ID_W-1:0] id;
        logic [255:0]    exp;
    } vec_t;

    localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
    localparam logic [511:0] BLK_ABC   = {32'h61626380, 448'h0, 32'h00000018};
    localparam logic [511:0] BLK_LONG0 = {
        32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
        32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
        32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
        32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam logic [511:0] BLK_LONG1 = {480'h0, 32'h000001c0};

    localparam logic [255:0] DG_EMPTY =
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    localparam logic [255:0] DG_ABC =
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] DG_LONG =
        256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{BLK_EMPTY, 1'b1, 8'h03, DG_EMPTY},
        '{BLK_ABC,   1'b1, 8'h05, DG_ABC},
        '{BLK_LONG0, 1'b0, 8'h09, 256'h0},
        '{BLK_LONG1, 1'b1, 8'h77, DG_LONG},
        '{BLK_ABC,   1'b1, 8'h01, DG_ABC}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic            in_ready;
    logic [511:0]    in_block;
    logic            in_last;
    logic [ID_W-1:0] in_id;
    logic            out_valid;
    logic            out_ready;
    logic [255:0]    out_digest;
    logic [ID_W-1:0] out_id;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    sha256_core #(.ID_W(ID_W)) u_sha256_core (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_block   (in_block),
        .in_last    (in_last),
        .in_id      (in_id),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_digest (out_digest),
        .out_id     (out_id)
    );

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [511:0] blk, logic last, logic [ID_W-1:0] id);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_block = blk;
        in_last  = last;
        in_id    = id;
        @(negedge clk);
        in_valid = 1'b0;
        in_block = '0;
    endtask

    task automatic wait_out();
        while (!out_valid) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ID_W-1:0] pkt_id;
        bit              new_pkt;
        int              lat;
        logic [255:0]    held;

        rst       = 1'b1;
        in_valid  = 1'b0;
        in_block  = '0;
        in_last   = 1'b0;
        in_id     = '0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 in_ready in reset", 256'(in_ready), 256'(1));
        check("R1 out_valid in reset", 256'(out_valid), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_ready after reset", 256'(in_ready), 256'(1));
        check("R1 out_valid after reset", 256'(out_valid), 256'(0));

        // Table walk: R2 single block, R3 chaining, R4 reinit, R8 id
        pkt_id  = '0;
        new_pkt = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (new_pkt) pkt_id = VECS[i].id;
            send(VECS[i].blk, VECS[i].last, VECS[i].id);
            if (VECS[i].last) begin
                wait_out();
                check($sformatf("R2/R3/R4 digest vec %0d", i), out_digest, VECS[i].exp);
                check($sformatf("R8 id vec %0d", i), 256'(out_id), 256'(pkt_id));
                @(negedge clk);
                check($sformatf("R7 release vec %0d", i), 256'(out_valid), 256'(0));
                new_pkt = 1'b1;
            end else begin
                check($sformatf("R6 ready low after accept vec %0d", i), 256'(in_ready), 256'(0));
                while (!in_ready) begin
                    if (out_valid) break;
                    @(negedge clk);
                end
                // R3: no digest before the last block
                check($sformatf("R3 no early digest vec %0d", i), 256'(out_valid), 256'(0));
                new_pkt = 1'b0;
            end
        end

        // R5: latency from accept edge
        send(BLK_ABC, 1'b1, 8'h2a);
        lat = 1;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R5 cycles to out_valid", 256'(lat), 256'(66));
        check("R2 latency run digest", out_digest, DG_ABC);
        @(negedge clk);

        // R6/R7: backpressure with junk offered while busy
        out_ready = 1'b0;
        send(BLK_EMPTY, 1'b1, 8'h44);
        in_valid = 1'b1;
        in_block = BLK_ABC;
        in_last  = 1'b0;
        in_id    = 8'h99;
        repeat (10) @(negedge clk);
        check("R6 ready low while busy", 256'(in_ready), 256'(0));
        wait_out();
        held = out_digest;
        check("R6 junk ignored digest", out_digest, DG_EMPTY);
        check("R8 junk ignored id", 256'(out_id), 256'(8'h44));
        repeat (12) @(negedge clk);
        check("R7 valid held", 256'(out_valid), 256'(1));
        check("R7 digest held", out_digest, held);
        check("R7 id held", 256'(out_id), 256'(8'h44));
        check("R6 ready low while out", 256'(in_ready), 256'(0));
        in_valid = 1'b0;
        in_block = '0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R7 release after stall", 256'(out_valid), 256'(0));

        // R4/R8: next packet clean after stall, two blocks with changing ids
        send(BLK_LONG0, 1'b0, 8'h10);
        send(BLK_LONG1, 1'b1, 8'h20);
        wait_out();
        check("R4 digest after stall", out_digest, DG_LONG);
        check("R8 first-block id", 256'(out_id), 256'(8'h10));
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule